// File: doc/BRIEF.md
# Renaming Register File

This block holds the architectural integer registers of an out-of-order core that renames destinations onto reorder-buffer slots. Next to its data word, every register keeps a producer tag (the reorder-buffer slot that will deliver its next value) and a ready flag that says no producer is outstanding. An instruction being issued reads up to two source registers and receives, for each, the stored word, the tag and the ready flag. In the same cycle it may claim a destination register, which takes the issuing slot as its new producer.

A second port retires results in program order. A retiring instruction that has a destination writes its value into the register. The ready flag is raised only if the register still names the retiring slot as its producer, because a younger instruction may have claimed the register since. When a source being read is retired in the same cycle, the read returns the retiring value as ready, so the consumer does not wait on a slot that is about to disappear. Register zero is a constant by default.

Top module: `rename_regfile`

## Requirements
- R1: After reset every register reads as value 0, tag 0, ready 1, and both source outputs hold value 0, tag 0, ready 1.
- R2: A retire with valid and has-destination set writes the retire value into the destination register (any register but x0).
- R3: A retire raises the destination's ready flag only if the register's stored tag equals the retire tag; on a mismatch the flag and tag keep their values.
- R4: A retire with has-destination clear changes no register value, tag or flag.
- R5: An issue with a source enabled returns that register's value, tag and ready flag on the source outputs one clock after the issue edge, reflecting the state before that edge.
- R6: If the enabled source equals a destination being written by a retire in the same cycle, the source outputs instead return the retire value with tag 0 and ready 1.
- R7: An issue with its destination enabled sets that register's tag to the issue tag and clears its ready flag.
- R8: When an issue renames the register that a same-cycle retire would make ready, the rename wins: the register ends with the issue tag and ready 0, while the retire value is still written.
- R9: Register x0 always reads as value 0, tag 0, ready 1; retires and renames aimed at it have no effect, and it never takes the bypass of R6.
- R10: A source output keeps its previous value, tag and ready flag in any cycle where no issue occurs or that source is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An instruction is issued this cycle |
| iss_tag | input | 5 | Reorder-buffer slot of the issuing instruction |
| iss_src1_en | input | 1 | First source is present |
| iss_src1_idx | input | 5 | First source register number |
| iss_src2_en | input | 1 | Second source is present |
| iss_src2_idx | input | 5 | Second source register number |
| iss_dst_en | input | 1 | Issuing instruction has a destination |
| iss_dst_idx | input | 5 | Destination register number to rename |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_has_dst | input | 1 | Retiring instruction writes a register |
| cmt_dst_idx | input | 5 | Register written by the retire |
| cmt_tag | input | 5 | Reorder-buffer slot of the retiring instruction |
| cmt_value | input | 32 | Result being retired |
| src1_value | output | 32 | First source data word |
| src1_tag | output | 5 | First source producer tag |
| src1_ready | output | 1 | First source has no outstanding producer |
| src2_value | output | 32 | Second source data word |
| src2_tag | output | 5 | Second source producer tag |
| src2_ready | output | 1 | Second source has no outstanding producer |

## Verification
Source outputs are registered, so a read issued before edge N shows up after edge N and reflects the state before N, with the same-cycle retire bypass folded in. A retire or rename applied at edge N becomes visible only to a read issued in the following cycle, whose result appears after edge N+1. The bench keeps a reference model that applies reads first and state updates second at each rising edge, drives inputs and compares all six source outputs at the falling edge, so every comparison lands half a cycle after the edge that produced it. Directed phases cover reset, renames, matching and stale retires, retires without a destination, same-cycle bypass, rename beating retire, register zero and held outputs, followed by a random run with a narrow tag range so tag matches are frequent.

// File: rtl/rtrf_pkg.sv
package rtrf_pkg;

   // Dependency action applied to one register at a clock edge
   typedef enum logic [1:0] {
      DEP_HOLD    = 2'd0,
      DEP_RESOLVE = 2'd1,
      DEP_RENAME  = 2'd2
   } dep_op_e;

   // A rename from issue overrides a resolve from retire
   function automatic dep_op_e pick_dep_op(input logic rename, input logic resolve);
      if (rename)
         return DEP_RENAME;
      else if (resolve)
         return DEP_RESOLVE;
      else
         return DEP_HOLD;
   endfunction

endpackage

// File: rtl/rtrf_entry.sv
module rtrf_entry
   import rtrf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int TAG_W      = 5,
   parameter bit FIXED_ZERO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  dep_op_e           dep_op,
   input  logic [TAG_W-1:0]  new_tag,
   output logic [DATA_W-1:0] value,
   output logic [TAG_W-1:0]  tag,
   output logic              ready
);

   generate
      if (FIXED_ZERO) begin : g_const
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, wr_en, wr_data, dep_op, new_tag};
         assign value = '0;
         assign tag   = '0;
         assign ready = 1'b1;
      end else begin : g_store
         logic [DATA_W-1:0] value_q;
         logic [TAG_W-1:0]  tag_q;
         logic              ready_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               value_q <= '0;
            end else if (wr_en) begin
               value_q <= wr_data;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q   <= '0;
               ready_q <= 1'b1;
            end else begin
               unique case (dep_op)
                  DEP_RENAME: begin
                     tag_q   <= new_tag;
                     ready_q <= 1'b0;
                  end
                  DEP_RESOLVE: ready_q <= 1'b1;
                  default: ;
               endcase
            end
         end

         assign value = value_q;
         assign tag   = tag_q;
         assign ready = ready_q;
      end
   endgenerate

endmodule

// File: rtl/rtrf_src_port.sv
module rtrf_src_port #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 5,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd_en,
   input  logic [IDX_W-1:0]                 rd_idx,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  bank_value,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   bank_tag,
   input  logic [NUM_REGS-1:0]              bank_ready,
   input  logic                             byp_hit,
   input  logic [DATA_W-1:0]                byp_value,
   output logic [DATA_W-1:0]                out_value,
   output logic [TAG_W-1:0]                 out_tag,
   output logic                             out_ready
);

   logic [DATA_W-1:0] sel_value;
   logic [TAG_W-1:0]  sel_tag;
   logic              sel_ready;

   always_comb begin
      if (byp_hit) begin
         sel_value = byp_value;
         sel_tag   = '0;
         sel_ready = 1'b1;
      end else begin
         sel_value = bank_value[rd_idx];
         sel_tag   = bank_tag[rd_idx];
         sel_ready = bank_ready[rd_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_value <= '0;
         out_tag   <= '0;
         out_ready <= 1'b1;
      end else if (rd_en) begin
         out_value <= sel_value;
         out_tag   <= sel_tag;
         out_ready <= sel_ready;
      end
   end

endmodule

// File: rtl/rename_regfile.sv
module rename_regfile
   import rtrf_pkg::*;
#(
   parameter int NUM_REGS       = 32,
   parameter int DATA_W         = 32,
   parameter int TAG_W          = 5,
   parameter bit ZERO_REG_FIXED = 1'b1,
   localparam int IDX_W         = $clog2(NUM_REGS),
   localparam int NUM_SRC       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   input  logic [TAG_W-1:0]  iss_tag,
   input  logic              iss_src1_en,
   input  logic [IDX_W-1:0]  iss_src1_idx,
   input  logic              iss_src2_en,
   input  logic [IDX_W-1:0]  iss_src2_idx,
   input  logic              iss_dst_en,
   input  logic [IDX_W-1:0]  iss_dst_idx,
   input  logic              cmt_valid,
   input  logic              cmt_has_dst,
   input  logic [IDX_W-1:0]  cmt_dst_idx,
   input  logic [TAG_W-1:0]  cmt_tag,
   input  logic [DATA_W-1:0] cmt_value,
   output logic [DATA_W-1:0] src1_value,
   output logic [TAG_W-1:0]  src1_tag,
   output logic              src1_ready,
   output logic [DATA_W-1:0] src2_value,
   output logic [TAG_W-1:0]  src2_tag,
   output logic              src2_ready
);

   // elaboration-time parameter checks
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("rename_regfile: NUM_REGS must be at least 2");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_pow2
      $error("rename_regfile: NUM_REGS must be a power of two");
   end
   if (TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("rename_regfile: TAG_W and DATA_W must be positive");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] val_vec;
   logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec;
   logic [NUM_REGS-1:0]             rdy_vec;

   // retire writes a real register (x0 is excluded when it is constant)
   logic cmt_writes;
   assign cmt_writes = cmt_valid && cmt_has_dst &&
                       !(ZERO_REG_FIXED && (cmt_dst_idx == '0));

   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_reg
         logic    hit_cmt;
         logic    hit_iss;
         dep_op_e op;

         assign hit_cmt = cmt_valid && cmt_has_dst && (cmt_dst_idx == IDX_W'(g));
         assign hit_iss = iss_valid && iss_dst_en && (iss_dst_idx == IDX_W'(g));
         assign op      = pick_dep_op(hit_iss, hit_cmt && (tag_vec[g] == cmt_tag));

         rtrf_entry #(
            .DATA_W     (DATA_W),
            .TAG_W      (TAG_W),
            .FIXED_ZERO (ZERO_REG_FIXED && (g == 0))
         ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit_cmt),
            .wr_data (cmt_value),
            .dep_op  (op),
            .new_tag (iss_tag),
            .value   (val_vec[g]),
            .tag     (tag_vec[g]),
            .ready   (rdy_vec[g])
         );
      end
   endgenerate

   logic [NUM_SRC-1:0]             rd_en;
   logic [NUM_SRC-1:0][IDX_W-1:0]  rd_idx;
   logic [NUM_SRC-1:0][DATA_W-1:0] rd_value;
   logic [NUM_SRC-1:0][TAG_W-1:0]  rd_tag;
   logic [NUM_SRC-1:0]             rd_ready;

   assign rd_en  = {iss_valid && iss_src2_en, iss_valid && iss_src1_en};
   assign rd_idx = {iss_src2_idx, iss_src1_idx};

   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_src
         rtrf_src_port #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .TAG_W    (TAG_W)
         ) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_en      (rd_en[g]),
            .rd_idx     (rd_idx[g]),
            .bank_value (val_vec),
            .bank_tag   (tag_vec),
            .bank_ready (rdy_vec),
            .byp_hit    (cmt_writes && (cmt_dst_idx == rd_idx[g])),
            .byp_value  (cmt_value),
            .out_value  (rd_value[g]),
            .out_tag    (rd_tag[g]),
            .out_ready  (rd_ready[g])
         );
      end
   endgenerate

   assign src1_value = rd_value[0];
   assign src1_tag   = rd_tag[0];
   assign src1_ready = rd_ready[0];
   assign src2_value = rd_value[1];
   assign src2_tag   = rd_tag[1];
   assign src2_ready = rd_ready[1];

endmodule

// File: rtl/rtrf_checker.sv
module rtrf_checker #(
   parameter int NUM_REGS       = 32,
   parameter int DATA_W         = 32,
   parameter int TAG_W          = 5,
   parameter bit ZERO_REG_FIXED = 1'b1,
   localparam int IDX_W         = $clog2(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            iss_valid,
   input logic [TAG_W-1:0]                iss_tag,
   input logic                            iss_src1_en,
   input logic [IDX_W-1:0]                iss_src1_idx,
   input logic                            iss_dst_en,
   input logic [IDX_W-1:0]                iss_dst_idx,
   input logic                            cmt_valid,
   input logic                            cmt_has_dst,
   input logic [IDX_W-1:0]                cmt_dst_idx,
   input logic [TAG_W-1:0]                cmt_tag,
   input logic [DATA_W-1:0]               cmt_value,
   input logic [DATA_W-1:0]               src1_value,
   input logic [TAG_W-1:0]                src1_tag,
   input logic                            src1_ready,
   input logic [NUM_REGS-1:0][TAG_W-1:0]  tag_vec,
   input logic [NUM_REGS-1:0]             rdy_vec
);

   logic rename_same;
   assign rename_same = iss_valid && iss_dst_en && (iss_dst_idx == cmt_dst_idx);

   // R3: matching tag, no competing rename -> ready next cycle
   p_resolve_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && cmt_has_dst && cmt_dst_idx != '0 && !rename_same &&
       tag_vec[cmt_dst_idx] == cmt_tag)
      |=> rdy_vec[$past(cmt_dst_idx)]);

   // R3: stale tag leaves the flag untouched
   p_stale_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && cmt_has_dst && !rename_same &&
       tag_vec[cmt_dst_idx] != cmt_tag)
      |=> rdy_vec[$past(cmt_dst_idx)] == $past(rdy_vec[cmt_dst_idx]));

   // R7 / R8: rename always leaves the register pending with the issue tag
   p_rename_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_dst_en && iss_dst_idx != '0)
      |=> !rdy_vec[$past(iss_dst_idx)] && tag_vec[$past(iss_dst_idx)] == $past(iss_tag));

   // R6: same-cycle retire is forwarded to the source output
   p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_src1_en && cmt_valid && cmt_has_dst &&
       cmt_dst_idx == iss_src1_idx && iss_src1_idx != '0)
      |=> src1_ready && src1_tag == '0 && src1_value == $past(cmt_value));

   // R10: no issue -> outputs hold
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !iss_valid |=> $stable(src1_value) && $stable(src1_tag) && $stable(src1_ready));

   generate
      if (ZERO_REG_FIXED) begin : g_zero_chk
         // R9: reading x0 yields a ready zero
         p_x0_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid && iss_src1_en && iss_src1_idx == '0)
            |=> src1_value == '0 && src1_tag == '0 && src1_ready);

         // R9: x0 is never pending
         always_comb begin
            if (rst_n) begin
               a_x0_ready_r9: assert (rdy_vec[0] && tag_vec[0] == '0);
            end
         end
      end
   endgenerate

endmodule

bind rename_regfile rtrf_checker #(
   .NUM_REGS       (NUM_REGS),
   .DATA_W         (DATA_W),
   .TAG_W          (TAG_W),
   .ZERO_REG_FIXED (ZERO_REG_FIXED)
) u_rtrf_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .iss_valid    (iss_valid),
   .iss_tag      (iss_tag),
   .iss_src1_en  (iss_src1_en),
   .iss_src1_idx (iss_src1_idx),
   .iss_dst_en   (iss_dst_en),
   .iss_dst_idx  (iss_dst_idx),
   .cmt_valid    (cmt_valid),
   .cmt_has_dst  (cmt_has_dst),
   .cmt_dst_idx  (cmt_dst_idx),
   .cmt_tag      (cmt_tag),
   .cmt_value    (cmt_value),
   .src1_value   (src1_value),
   .src1_tag     (src1_tag),
   .src1_ready   (src1_ready),
   .tag_vec      (tag_vec),
   .rdy_vec      (rdy_vec)
);

// File: tb/test_rename_regfile.sv
`timescale 1ns/1ps
module test_rename_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iss_valid = 1'b0;
   logic [4:0]  iss_tag = '0;
   logic        iss_src1_en = 1'b0;
   logic [4:0]  iss_src1_idx = '0;
   logic        iss_src2_en = 1'b0;
   logic [4:0]  iss_src2_idx = '0;
   logic        iss_dst_en = 1'b0;
   logic [4:0]  iss_dst_idx = '0;
   logic        cmt_valid = 1'b0;
   logic        cmt_has_dst = 1'b0;
   logic [4:0]  cmt_dst_idx = '0;
   logic [4:0]  cmt_tag = '0;
   logic [31:0] cmt_value = '0;
   logic [31:0] src1_value, src2_value;
   logic [4:0]  src1_tag, src2_tag;
   logic        src1_ready, src2_ready;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   rename_regfile i_rename_regfile (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_tag(iss_tag),
      .iss_src1_en(iss_src1_en), .iss_src1_idx(iss_src1_idx),
      .iss_src2_en(iss_src2_en), .iss_src2_idx(iss_src2_idx),
      .iss_dst_en(iss_dst_en), .iss_dst_idx(iss_dst_idx),
      .cmt_valid(cmt_valid), .cmt_has_dst(cmt_has_dst),
      .cmt_dst_idx(cmt_dst_idx), .cmt_tag(cmt_tag), .cmt_value(cmt_value),
      .src1_value(src1_value), .src1_tag(src1_tag), .src1_ready(src1_ready),
      .src2_value(src2_value), .src2_tag(src2_tag), .src2_ready(src2_ready)
   );

   // behavioural reference model
   logic [31:0] m_val [32];
   logic [4:0]  m_tag [32];
   logic        m_rdy [32];
   logic [31:0] e_val [2];
   logic [4:0]  e_tag [2];
   logic        e_rdy [2];

   task automatic model_reset();
      for (int i = 0; i < 32; i++) begin
         m_val[i] = '0; m_tag[i] = '0; m_rdy[i] = 1'b1;
      end
      for (int s = 0; s < 2; s++) begin
         e_val[s] = '0; e_tag[s] = '0; e_rdy[s] = 1'b1;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         for (int s = 0; s < 2; s++) begin
            logic en;
            int   idx;
            en  = (s == 0) ? iss_src1_en : iss_src2_en;
            idx = (s == 0) ? int'(iss_src1_idx) : int'(iss_src2_idx);
            if (iss_valid && en) begin
               if (idx == 0) begin
                  e_val[s] = '0; e_tag[s] = '0; e_rdy[s] = 1'b1;
               end else if (cmt_valid && cmt_has_dst && int'(cmt_dst_idx) == idx) begin
                  e_val[s] = cmt_value; e_tag[s] = '0; e_rdy[s] = 1'b1;
               end else begin
                  e_val[s] = m_val[idx]; e_tag[s] = m_tag[idx]; e_rdy[s] = m_rdy[idx];
               end
            end
         end
         if (cmt_valid && cmt_has_dst && cmt_dst_idx != 0) begin
            m_val[cmt_dst_idx] = cmt_value;
            if (m_tag[cmt_dst_idx] == cmt_tag) m_rdy[cmt_dst_idx] = 1'b1;
         end
         if (iss_valid && iss_dst_en && iss_dst_idx != 0) begin
            m_tag[iss_dst_idx] = iss_tag;
            m_rdy[iss_dst_idx] = 1'b0;
         end
      end
   end

   task automatic check_src(int s, logic [31:0] av, logic [4:0] at, logic ar);
      checks++;
      if (av !== e_val[s] || at !== e_tag[s] || ar !== e_rdy[s]) begin
         failures++;
         $display("FAIL %s src%0d: actual value=%h tag=%0d ready=%0d expected value=%h tag=%0d ready=%0d",
                  cur_req, s + 1, av, at, ar, e_val[s], e_tag[s], e_rdy[s]);
      end
   endtask

   task automatic check_outputs();
      check_src(0, src1_value, src1_tag, src1_ready);
      check_src(1, src2_value, src2_tag, src2_ready);
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      check_outputs();
   endtask

   task automatic idle();
      iss_valid = 0; iss_src1_en = 0; iss_src2_en = 0; iss_dst_en = 0;
      cmt_valid = 0; cmt_has_dst = 0;
   endtask

   task automatic rd(int a, int b);
      iss_valid = 1; iss_src1_en = 1; iss_src1_idx = 5'(a);
      iss_src2_en = 1; iss_src2_idx = 5'(b);
   endtask

   task automatic ren(int d, int t);
      iss_valid = 1; iss_dst_en = 1; iss_dst_idx = 5'(d); iss_tag = 5'(t);
   endtask

   task automatic ret(bit has, int d, int t, logic [31:0] v);
      cmt_valid = 1; cmt_has_dst = has; cmt_dst_idx = 5'(d); cmt_tag = 5'(t); cmt_value = v;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check_outputs();
      rst_n = 1'b1;
      // R1: every register reads as ready zero
      for (int i = 0; i < 16; i++) begin
         idle(); rd(i, i + 16); cyc();
      end
      // R7: rename x1..x5
      cur_req = "R7";
      for (int i = 1; i <= 5; i++) begin
         idle(); ren(i, i + 2); cyc();
      end
      idle(); rd(1, 2); cyc();
      idle(); rd(3, 4); cyc();
      idle(); rd(5, 1); cyc();
      // R2/R3: matching retire on x1, stale retire on x2
      cur_req = "R2";
      idle(); ret(1, 1, 3, 32'hA5A5_0001); cyc();
      cur_req = "R3";
      idle(); ret(1, 2, 9, 32'h0BB0_0002); cyc();
      idle(); rd(1, 2); cyc();
      // R4: retire without destination
      cur_req = "R4";
      idle(); ret(0, 4, 6, 32'hCCCC_CCCC); cyc();
      idle(); rd(4, 3); cyc();
      // R6: bypass on both sources
      cur_req = "R6";
      idle(); rd(3, 3); ret(1, 3, 5, 32'hD00D_0003); cyc();
      idle(); rd(3, 1); cyc();
      // R8: rename beats same-cycle resolve
      cur_req = "R8";
      idle(); ren(5, 11); ret(1, 5, 7, 32'hEEEE_0005); cyc();
      idle(); rd(5, 0); cyc();
      // R9: x0 is constant
      cur_req = "R9";
      idle(); ret(1, 0, 0, 32'hFFFF_FFFF); ren(0, 13); cyc();
      idle(); rd(0, 0); ret(1, 0, 0, 32'h1234_5678); cyc();
      idle(); rd(0, 5); cyc();
      // R10: outputs hold
      cur_req = "R10";
      idle(); rd(1, 3); cyc();
      idle(); ret(1, 1, 3, 32'h7777_0001); iss_src1_idx = 5'd9; cyc();
      idle(); iss_valid = 1; iss_src1_idx = 5'd1; iss_src2_idx = 5'd1; cyc();
      idle(); iss_valid = 1; iss_src2_en = 1; iss_src2_idx = 5'd1; iss_src1_idx = 5'd4; cyc();
      // R5: random traffic
      cur_req = "R5";
      for (int n = 0; n < 600; n++) begin
         iss_valid    = ($urandom % 4) != 0;
         iss_tag      = 5'($urandom % 4);
         iss_src1_en  = $urandom % 2;
         iss_src1_idx = 5'($urandom % 8);
         iss_src2_en  = $urandom % 2;
         iss_src2_idx = 5'($urandom % 8);
         iss_dst_en   = $urandom % 2;
         iss_dst_idx  = 5'($urandom % 8);
         cmt_valid    = $urandom % 2;
         cmt_has_dst  = ($urandom % 4) != 0;
         cmt_dst_idx  = 5'($urandom % 8);
         cmt_tag      = 5'($urandom % 4);
         cmt_value    = $urandom;
         cyc();
      end
      idle(); cyc();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule